// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block sits beside the command pins of a single-rank, four-bank SDRAM and watches them without driving anything. Every clock it turns clock enable, chip select and the three strobes into one command, follows each bank between idle and open, and counts the cycles since each bank's last activate and precharge. It also counts the cycles since the last auto refresh. When a command breaks a spacing rule, or the refresh deadline passes, it records a code for that first violation and raises a sticky flag.

The spacing limits are parameters in clock cycles. The defaults come from nanosecond limits at a 7.5 ns clock: precharge period 3, activate-to-access 3, minimum open time 6, activate-to-activate on another bank 2, mode-set recovery 2, and a refresh interval of 1041 cycles (64 ms shared over 8192 refreshes). The checker is meant for simulation benches and emulation builds, where the first code points straight at the offending cycle.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high and chip select low, the strobes {ras_n, cas_n, we_n} decode as 000 mode set, 001 auto refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 no-operation; a legal sequence of these raises no error.
- R2: A cycle with chip select high or clock enable low is a no-operation: it leaves every bank's state unchanged and breaks no rule.
- R3: An activate to a bank fewer than T_RP (3) cycles after that bank was precharged records code 3.
- R4: A read or write fewer than T_RCD (3) cycles after the activate of the same bank records code 6.
- R5: A precharge of an open bank fewer than T_RAS (6) cycles after its activate records code 7.
- R6: An activate fewer than T_RRD (2) cycles after an activate to a different bank records code 4.
- R7: Any command other than no-operation fewer than T_MRD (2) cycles after a mode set records code 1.
- R8: When REFI (1041) cycles pass after an auto refresh and the cycle REFI cycles after it carries no auto refresh either, code 8 is recorded.
- R9: A read or write to an idle bank records code 5.
- R10: An activate to a bank that is already open records code 2.
- R11: A precharge with a10 high closes all banks and starts the precharge period of every bank.
- R12: A read or write with a10 high closes the bank at once, and a new activate to it is legal only BURST_LEN + T_RP (7) cycles after the access.
- R13: After reset err_flag is 0 and err_code is 0; the first violation sets both one cycle after the offending command and they then hold until reset; when one command breaks several rules, the lowest code is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable as seen at the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10: all-banks or auto-precharge select |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation, 0 when none |

## Verification
The bound checker checks on every cycle that the flag and code never change once set, that the code is zero while the flag is clear, that deselected or clock-disabled cycles leave the bank states alone, that an all-banks precharge leaves every bank idle, and that an access to an idle bank or an activate to an open bank raises the flag on the next cycle. The exact spacing limits, where one cycle separates a legal command from a violation, the auto-precharge window, the refresh deadline after more than a thousand cycles and the choice among codes when several rules break at once show only in the bench's directed scenarios, each driven right up to and just past its boundary.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_MRS = 3'd1,
      CMD_REF = 3'd2,
      CMD_PRE = 3'd3,
      CMD_ACT = 3'd4,
      CMD_WR  = 3'd5,
      CMD_RD  = 3'd6,
      CMD_BST = 3'd7
   } sdc_cmd_e;

   localparam int ERR_W     = 4;
   localparam int NUM_CODES = 9;

   typedef enum logic [ERR_W-1:0] {
      ERR_NONE     = 4'd0,
      ERR_MRD      = 4'd1,
      ERR_ACT_OPEN = 4'd2,
      ERR_RP       = 4'd3,
      ERR_RRD      = 4'd4,
      ERR_IDLE     = 4'd5,
      ERR_RCD      = 4'd6,
      ERR_RAS      = 4'd7,
      ERR_REF      = 4'd8
   } sdc_err_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
   import sdc_pkg::*;
(
   input  logic     cke_i,
   input  logic     cs_n_i,
   input  logic     ras_n_i,
   input  logic     cas_n_i,
   input  logic     we_n_i,
   output sdc_cmd_e cmd_o
);

   // R1: strobe encodings; R2: deselect or frozen clock reads as no-operation
   always_comb begin
      cmd_o = CMD_NOP;
      if (cke_i && !cs_n_i) begin
         unique case ({ras_n_i, cas_n_i, we_n_i})
            3'b000:  cmd_o = CMD_MRS;
            3'b001:  cmd_o = CMD_REF;
            3'b010:  cmd_o = CMD_PRE;
            3'b011:  cmd_o = CMD_ACT;
            3'b100:  cmd_o = CMD_WR;
            3'b101:  cmd_o = CMD_RD;
            3'b110:  cmd_o = CMD_BST;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track
   import sdc_pkg::*;
#(
   parameter int T_RP      = 3,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int BURST_LEN = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  sdc_cmd_e cmd_i,
   input  logic     sel_i,
   input  logic     a10_i,
   output logic     open_o,
   output logic     v_act_open_o,
   output logic     v_rp_o,
   output logic     v_idle_o,
   output logic     v_rcd_o,
   output logic     v_ras_o
);

   localparam int AP_WAIT = BURST_LEN + T_RP;
   localparam int CW      = $clog2(max2(max2(T_RAS, T_RCD), AP_WAIT) + 1);

   logic          open_q;
   logic [CW-1:0] rp_left_q;
   logic [CW-1:0] rcd_left_q;
   logic [CW-1:0] ras_left_q;

   logic act_hit, rw_hit, pre_hit;

   assign act_hit = (cmd_i == CMD_ACT) && sel_i;
   assign rw_hit  = ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && sel_i;
   assign pre_hit = (cmd_i == CMD_PRE) && (sel_i || a10_i);

   // rule checks against the state held before this command
   assign v_act_open_o = act_hit && open_q;
   assign v_rp_o       = act_hit && !open_q && (rp_left_q != '0);
   assign v_idle_o     = rw_hit && !open_q;
   assign v_rcd_o      = rw_hit && open_q && (rcd_left_q != '0);
   assign v_ras_o      = pre_hit && open_q && (ras_left_q != '0);
   assign open_o       = open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         rp_left_q  <= '0;
         rcd_left_q <= '0;
         ras_left_q <= '0;
      end else begin
         if (rp_left_q != '0)  rp_left_q  <= rp_left_q - 1'b1;
         if (rcd_left_q != '0) rcd_left_q <= rcd_left_q - 1'b1;
         if (ras_left_q != '0) ras_left_q <= ras_left_q - 1'b1;
         if (act_hit) begin
            open_q     <= 1'b1;
            rcd_left_q <= CW'(T_RCD - 1);
            ras_left_q <= CW'(T_RAS - 1);
         end else if (pre_hit) begin
            // R11: one bank or all banks close and start the precharge period
            open_q    <= 1'b0;
            rp_left_q <= CW'(T_RP - 1);
         end else if (rw_hit && a10_i && open_q) begin
            // R12: precharge period begins once the burst has finished
            open_q    <= 1'b0;
            rp_left_q <= CW'(AP_WAIT - 1);
         end
      end
   end

endmodule

// File: rtl/sdc_spacing_guard.sv
module sdc_spacing_guard
   import sdc_pkg::*;
#(
   parameter int T_RRD = 2,
   parameter int T_MRD = 2,
   parameter int BA_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  sdc_cmd_e        cmd_i,
   input  logic [BA_W-1:0] ba_i,
   output logic            v_rrd_o,
   output logic            v_mrd_o
);

   localparam int GW = $clog2(max2(T_RRD, T_MRD) + 1);

   logic [GW-1:0]   rrd_left_q;
   logic [GW-1:0]   mrd_left_q;
   logic [BA_W-1:0] last_act_q;

   // R6: activates to different banks too close together
   assign v_rrd_o = (cmd_i == CMD_ACT) && (rrd_left_q != '0) && (ba_i != last_act_q);
   // R7: anything but no-operation inside the mode-set recovery window
   assign v_mrd_o = (cmd_i != CMD_NOP) && (mrd_left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rrd_left_q <= '0;
         mrd_left_q <= '0;
         last_act_q <= '0;
      end else begin
         if (rrd_left_q != '0) rrd_left_q <= rrd_left_q - 1'b1;
         if (mrd_left_q != '0) mrd_left_q <= mrd_left_q - 1'b1;
         if (cmd_i == CMD_ACT) begin
            rrd_left_q <= GW'(T_RRD - 1);
            last_act_q <= ba_i;
         end
         if (cmd_i == CMD_MRS) mrd_left_q <= GW'(T_MRD - 1);
      end
   end

endmodule

// File: rtl/sdc_refresh_watch.sv
module sdc_refresh_watch
   import sdc_pkg::*;
#(
   parameter int REFI = 1041
) (
   input  logic     clk,
   input  logic     rst_n,
   input  sdc_cmd_e cmd_i,
   output logic     v_ref_o
);

   localparam int NW = $clog2(REFI + 1);

   // holds k in the cycle k cycles after the last auto refresh, saturating at REFI
   logic [NW-1:0] since_q;

   // R8: the last allowed cycle went by without an auto refresh
   assign v_ref_o = (since_q >= NW'(REFI)) && (cmd_i != CMD_REF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (cmd_i == CMD_REF) begin
         since_q <= NW'(1);
      end else if (since_q < NW'(REFI)) begin
         since_q <= since_q + 1'b1;
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdc_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RP      = 3,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RRD     = 2,
   parameter int T_MRD     = 2,
   parameter int BURST_LEN = 4,
   parameter int REFI      = 1041,
   parameter bit REF_CHECK = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cke,
   input  logic                        cs_n,
   input  logic                        ras_n,
   input  logic                        cas_n,
   input  logic                        we_n,
   input  logic [$clog2(NUM_BANKS)-1:0] ba,
   input  logic                        a10,
   output logic                        err_flag,
   output logic [ERR_W-1:0]            err_code
);

   localparam int BA_W = $clog2(NUM_BANKS);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (T_RP < 1 || T_RCD < 1 || T_RAS < 1 || T_RRD < 1 || T_MRD < 1) begin : g_chk_t
      $error("spacing limits must be at least one cycle");
   end
   if (BURST_LEN < 1 || REFI < 2) begin : g_chk_misc
      $error("BURST_LEN must be positive and REFI at least 2");
   end

   sdc_cmd_e cmd;

   sdc_cmd_decode u_decode (
      .cke_i   (cke),
      .cs_n_i  (cs_n),
      .ras_n_i (ras_n),
      .cas_n_i (cas_n),
      .we_n_i  (we_n),
      .cmd_o   (cmd)
   );

   logic [NUM_BANKS-1:0] bank_open;
   logic [NUM_BANKS-1:0] v_act_open, v_rp, v_idle, v_rcd, v_ras;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdc_bank_track #(
         .T_RP      (T_RP),
         .T_RCD     (T_RCD),
         .T_RAS     (T_RAS),
         .BURST_LEN (BURST_LEN)
      ) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .cmd_i        (cmd),
         .sel_i        (ba == BA_W'(g)),
         .a10_i        (a10),
         .open_o       (bank_open[g]),
         .v_act_open_o (v_act_open[g]),
         .v_rp_o       (v_rp[g]),
         .v_idle_o     (v_idle[g]),
         .v_rcd_o      (v_rcd[g]),
         .v_ras_o      (v_ras[g])
      );
   end

   logic v_rrd, v_mrd, v_ref;

   sdc_spacing_guard #(
      .T_RRD (T_RRD),
      .T_MRD (T_MRD),
      .BA_W  (BA_W)
   ) u_spacing (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd),
      .ba_i    (ba),
      .v_rrd_o (v_rrd),
      .v_mrd_o (v_mrd)
   );

   if (REF_CHECK) begin : g_ref_on
      sdc_refresh_watch #(
         .REFI (REFI)
      ) u_refresh (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_i   (cmd),
         .v_ref_o (v_ref)
      );
   end else begin : g_ref_off
      assign v_ref = 1'b0;
   end

   // violation vector indexed by error code
   logic [NUM_CODES-1:0] viol;

   always_comb begin
      viol               = '0;
      viol[ERR_MRD]      = v_mrd;
      viol[ERR_ACT_OPEN] = |v_act_open;
      viol[ERR_RP]       = |v_rp;
      viol[ERR_RRD]      = v_rrd;
      viol[ERR_IDLE]     = |v_idle;
      viol[ERR_RCD]      = |v_rcd;
      viol[ERR_RAS]      = |v_ras;
      viol[ERR_REF]      = v_ref;
   end

   // R13: lowest code wins when several rules break together
   logic [ERR_W-1:0] code_nxt;

   always_comb begin
      code_nxt = '0;
      for (int i = NUM_CODES - 1; i >= 1; i--) begin
         if (viol[i]) code_nxt = ERR_W'(i);
      end
   end

   // R13: first violation captured and held until reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag <= 1'b0;
         err_code <= '0;
      end else if (!err_flag && (code_nxt != '0)) begin
         err_flag <= 1'b1;
         err_code <= code_nxt;
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor_sva.sv
module sdram_cmd_monitor_sva #(
   parameter int NUM_BANKS = 4,
   parameter int ERR_W     = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cke,
   input logic                         cs_n,
   input logic                         ras_n,
   input logic                         cas_n,
   input logic                         we_n,
   input logic [$clog2(NUM_BANKS)-1:0] ba,
   input logic                         a10,
   input logic                         err_flag,
   input logic [ERR_W-1:0]             err_code,
   input logic [NUM_BANKS-1:0]         bank_open
);

   logic live;
   assign live = cke && !cs_n;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag) else $error("flag dropped");                           // R13

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> $stable(err_code)) else $error("code changed");                  // R13

   AST_CODE_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !err_flag |-> (err_code == '0)) else $error("code without flag");              // R13

   AST_IGNORED_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || cs_n) |=> $stable(bank_open)) else $error("ignored cycle moved banks"); // R2

   AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !ras_n && cas_n && !we_n && a10) |=> (bank_open == '0))
      else $error("bank left open");                                                // R11

   AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (live && ras_n && !cas_n && !bank_open[ba]) |=> err_flag)
      else $error("idle access missed");                                            // R9

   AST_DOUBLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !ras_n && cas_n && we_n && bank_open[ba]) |=> err_flag)
      else $error("double activate missed");                                        // R10

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_sva #(
   .NUM_BANKS (NUM_BANKS),
   .ERR_W     (sdc_pkg::ERR_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .a10       (a10),
   .err_flag  (err_flag),
   .err_code  (err_code),
   .bank_open (bank_open)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

   localparam int REFI = 1041;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1;
   logic       ras_n = 1'b1;
   logic       cas_n = 1'b1;
   logic       we_n = 1'b1;
   logic [1:0] ba = '0;
   logic       a10 = 1'b0;
   logic       err_flag;
   logic [3:0] err_code;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   sdram_cmd_monitor dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .a10      (a10),
      .err_flag (err_flag),
      .err_code (err_code)
   );

   task automatic put(input logic k, input logic c, input logic r, input logic ca,
                      input logic w, input logic [1:0] b, input logic a);
      @(negedge clk);
      cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
   endtask

   task automatic act(input logic [1:0] b);               put(1, 0, 0, 1, 1, b, 0); endtask
   task automatic rd(input logic [1:0] b, input logic ap); put(1, 0, 1, 0, 1, b, ap); endtask
   task automatic wr(input logic [1:0] b, input logic ap); put(1, 0, 1, 0, 0, b, ap); endtask
   task automatic pre(input logic [1:0] b, input logic all); put(1, 0, 0, 1, 0, b, all); endtask
   task automatic mrs();                                  put(1, 0, 0, 0, 0, 2'd0, 0); endtask
   task automatic refr();                                 put(1, 0, 0, 0, 1, 2'd0, 0); endtask
   task automatic nop();                                  put(1, 0, 1, 1, 1, 2'd0, 0); endtask
   task automatic nops(input int n);
      for (int i = 0; i < n; i++) nop();
   endtask

   // samples just after the edge that takes the last driven command
   task automatic expect_err(input logic ef, input logic [3:0] ec, input string req);
      @(posedge clk);
      #1;
      tests++;
      if (err_flag !== ef || err_code !== ec) begin
         fails++;
         $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d",
                  req, err_flag, err_code, ef, ec);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      ba = '0; a10 = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      tests++;
      if (err_flag !== 1'b0 || err_code !== 4'd0) begin
         fails++;
         $display("FAIL R13 reset: flag=%0b code=%0d expected flag=0 code=0", err_flag, err_code);
      end
   endtask

   task automatic t_legal();
      do_reset();
      act(0); nop(); act(1); nop(); nop();
      rd(1, 0);                       // three after its activate: R4 boundary
      expect_err(0, 0, "R4 access at limit");
      wr(0, 0); pre(0, 0);            // precharge seven after activate: R5
      nop(); nop(); act(0);           // three after precharge: R3 boundary
      refr(); put(1, 0, 1, 1, 0, 2'd0, 0);
      expect_err(0, 0, "R1 legal sequence");
   endtask

   task automatic t_rcd();
      do_reset();
      act(1); nop(); rd(1, 0);
      expect_err(1, 6, "R4 access too early");
   endtask

   task automatic t_ras();
      do_reset();
      act(2); nops(4); pre(2, 0);
      expect_err(1, 7, "R5 precharge too early");
   endtask

   task automatic t_rp();
      do_reset();
      act(0); nops(5); pre(0, 0); nop(); act(0);
      expect_err(1, 3, "R3 activate too early");
   endtask

   task automatic t_rrd();
      do_reset();
      act(0); act(1);
      expect_err(1, 4, "R6 activates too close");
   endtask

   task automatic t_mrd();
      do_reset();
      mrs(); nop(); act(0);
      expect_err(0, 0, "R7 command at limit");
      mrs(); act(1);
      expect_err(1, 1, "R7 command too early");
   endtask

   task automatic t_idle();
      do_reset();
      wr(2, 0);
      expect_err(1, 5, "R9 idle access");
   endtask

   task automatic t_dbl();
      do_reset();
      act(3); nops(2); act(3);
      expect_err(1, 2, "R10 double activate");
   endtask

   task automatic t_ignore();
      do_reset();
      act(0); mrs();
      put(1, 1, 0, 1, 1, 2'd1, 0);    // deselected activate right after mode set
      expect_err(0, 0, "R2 deselected cycle");
      put(0, 0, 1, 0, 1, 2'd2, 0);    // clock disabled read of idle bank
      put(1, 1, 0, 1, 0, 2'd0, 0);    // deselected precharge of open bank
      rd(0, 0);
      expect_err(0, 0, "R2 bank kept open");
   endtask

   task automatic t_preall();
      do_reset();
      act(0); nop(); act(1); nops(5); pre(0, 1);
      expect_err(0, 0, "R11 legal precharge all");
      rd(1, 0);
      expect_err(1, 5, "R11 bank closed by precharge all");
      do_reset();
      pre(2, 1); act(3);
      expect_err(1, 3, "R11 period started on all banks");
   endtask

   task automatic t_autopre();
      do_reset();
      act(0); nops(2); rd(0, 1); rd(0, 0);
      expect_err(1, 5, "R12 bank closed by auto precharge");
      do_reset();
      act(0); nops(2); wr(0, 1); nops(5); act(0);
      expect_err(1, 3, "R12 activate one cycle early");
      do_reset();
      act(0); nops(2); rd(0, 1); nops(6); act(0);
      expect_err(0, 0, "R12 activate at limit");
   endtask

   task automatic t_refresh();
      do_reset();
      refr(); nops(REFI - 1); refr();
      expect_err(0, 0, "R8 refresh at limit");
      nops(REFI - 1);
      expect_err(0, 0, "R8 before deadline");
      nop();
      expect_err(1, 8, "R8 refresh missed");
   endtask

   task automatic t_first();
      do_reset();
      act(1); nop(); rd(1, 0);
      expect_err(1, 6, "R13 first capture");
      pre(1, 0);
      expect_err(1, 6, "R13 later violation ignored");
      do_reset();
      act(1); nops(2); mrs(); act(1);
      expect_err(1, 1, "R13 lowest code wins");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_legal();
      t_rcd();
      t_ras();
      t_rp();
      t_rrd();
      t_mrd();
      t_idle();
      t_dbl();
      t_ignore();
      t_preall();
      t_autopre();
      t_refresh();
      t_first();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule